// File: doc/BRIEF.md
# Dual-Mode LCD Panel Timing Generator

This block scans an LCD panel. From a system clock it derives a pixel clock and walks a grid of pixel slots. A line is made of a sync stretch, a back porch, the visible pixels and a front porch. A frame is made of sync lines, back-porch lines, visible lines and front-porch lines. It drives a horizontal sync, a vertical sync, a pixel clock, an AC/enable output and a 16-bit pixel bus. For every visible slot it pulls one pixel word from a ready/valid source. If the source has no word ready, it shows a zero pixel and raises a sticky underflow flag.

A static mode input selects how two of the outputs behave. In active-matrix mode the pixel clock runs through blanking, and the AC output is the data enable: it is high exactly while a visible pixel is on the bus. In passive-matrix mode the pixel clock pulses only during visible slots. The AC output then becomes a drive-polarity signal that inverts after a programmable number of frames, so that no DC bias builds up across the panel.

Each pixel slot lasts D system clocks, where D is the programmed divisor, with values below 2 treated as 2. Pixel data, syncs and the enable change together with the falling edge of the pixel clock. This keeps them steady across the rising edge, where the panel samples them.

Top module: `lcdTimingGen`

## Requirements
- R1: While reset is high, and from one clock after `enable` is sampled low, the outputs `lcdHsync`, `lcdVsync`, `lcdPclk`, `lcdAc` and `lcdData` are all 0 and `pixReady` is 0. Reset also clears `underflow`. Dropping `enable` leaves `underflow` unchanged.
- R2: When `enable` is sampled high while idle, the first slot of a frame (line 0, column 0) is loaded on that same clock edge. Each later slot is loaded exactly D clocks after the previous one.
- R3: Within a line, slot columns run in this order: `hSyncWidth` sync slots, `hBackPorch` slots, `pixPerLine` visible slots, `hFrontPorch` slots. `lcdHsync` is high (active-high) during the sync slots of every line.
- R4: Within a frame, lines run in this order: `vSyncWidth` sync lines, `vBackPorch` lines, `linesPerFrame` visible lines, `vFrontPorch` lines. `lcdVsync` is high during every slot of the sync lines.
- R5: In each slot where the pixel clock is allowed to run, `lcdPclk` is low for the first floor(D/2) clocks and high for the remaining clocks. Syncs, enable and data change only while `lcdPclk` is low. In active mode (`activeMode`=1) the clock runs in every slot.
- R6: In passive mode (`activeMode`=0), `lcdPclk` stays low through all non-visible slots.
- R7: In active mode, `lcdAc` is high exactly during visible slots, and `lcdData` is 0 whenever `lcdAc` is low.
- R8: In passive mode, `lcdAc` starts at 0 and inverts at the start of each frame that follows N+1 completed frames, where N is `acPeriod`. N=0 inverts it every frame.
- R9: `pixReady` is high for one clock, on the clock edge that loads each visible slot. A word accepted there (`pixValid`=1) appears on `lcdData` for that whole slot. `lcdData` is 0 in non-visible slots.
- R10: If `pixValid` is 0 while `pixReady` is high, the slot shows pixel 0 and `underflow` becomes 1. `underflow` stays 1 until a clock with `underflowClr`=1, and a new underflow on that same clock keeps it at 1.
- R11: A `clkDiv` of 0 or 1 gives the same timing as `clkDiv`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Start/continue scanning; low stops and blanks outputs |
| activeMode | input | 1 | 1 = active-matrix, 0 = passive-matrix (static) |
| pixPerLine | input | 10 | Visible pixels per line |
| hSyncWidth | input | 10 | Horizontal sync width in pixel slots |
| hBackPorch | input | 10 | Slots between sync and visible pixels |
| hFrontPorch | input | 10 | Slots after visible pixels |
| linesPerFrame | input | 10 | Visible lines per frame |
| vSyncWidth | input | 10 | Vertical sync width in lines |
| vBackPorch | input | 10 | Lines between sync and visible lines |
| vFrontPorch | input | 10 | Lines after visible lines |
| clkDiv | input | 8 | System clocks per pixel slot (min 2) |
| acPeriod | input | 6 | Passive polarity toggle period minus one, in frames |
| pixData | input | 16 | Pixel word from source |
| pixValid | input | 1 | Source has a pixel word |
| pixReady | output | 1 | Block takes a pixel word this clock |
| underflowClr | input | 1 | Clears the underflow flag |
| underflow | output | 1 | Sticky underflow flag |
| lcdVsync | output | 1 | Vertical sync / frame start |
| lcdHsync | output | 1 | Horizontal sync / line boundary |
| lcdAc | output | 1 | Data enable (active) or drive polarity (passive) |
| lcdPclk | output | 1 | Pixel clock |
| lcdData | output | 16 | Pixel bus |

## Verification
A wrong divider or slot counter appears at once as a misplaced pixel-clock edge or a sync pulse on the wrong slot. The bench compares every output on every clock against a slot model that is built from the programmed geometry, so such an error is caught within one slot of its first effect. A wrong frame count or polarity counter only shows up at a frame boundary, so each configuration runs for several frames and with more than one toggle period. A stale fetch or a mishandled underflow shows on the bus or the flag in the slot that follows the fetch. The source's valid signal is therefore randomized, and the underflow clear is pulsed at random times, so that it sometimes coincides with a new underflow.

// File: rtl/lcdTimingPkg.sv
package lcdTimingPkg;
  // Per-clock strobes from the scan controller to the output datapath
  typedef struct packed {
    logic load;        // a new pixel slot starts this edge
    logic frameWrap;   // the new slot is the first of a following frame
    logic nextActive;  // new slot is a visible pixel
    logic nextHsync;   // new slot lies in horizontal sync
    logic nextVsync;   // new slot lies in vertical sync
    logic pclkRise;    // mid-slot point: pixel clock may go high
    logic halt;        // reset or disabled: blank everything
  } lcdStrobeT;
endpackage

// File: rtl/lcdTimingCtrl.sv
module lcdTimingCtrl
  import lcdTimingPkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] pixPerLine,
  input  logic [CNT_W-1:0] hSyncWidth,
  input  logic [CNT_W-1:0] hBackPorch,
  input  logic [CNT_W-1:0] hFrontPorch,
  input  logic [CNT_W-1:0] linesPerFrame,
  input  logic [CNT_W-1:0] vSyncWidth,
  input  logic [CNT_W-1:0] vBackPorch,
  input  logic [CNT_W-1:0] vFrontPorch,
  input  logic [DIV_W-1:0] clkDiv,
  output lcdStrobeT        strobe
);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic             running;
  logic [DIV_W-1:0] divCnt;
  logic [SUM_W-1:0] hCnt, vCnt, nextH, nextV;
  logic [DIV_W-1:0] divEff, divLast, divHalf;
  logic [SUM_W-1:0] hTotal, vTotal, hActStart, hActEnd, vActStart, vActEnd;
  logic             startNow, tick, hLast, vLast;

  assign divEff  = (clkDiv < MIN_DIV) ? MIN_DIV : clkDiv;
  assign divLast = divEff - DIV_W'(1);
  assign divHalf = divEff >> 1;

  assign hActStart = SUM_W'(hSyncWidth) + SUM_W'(hBackPorch);
  assign hActEnd   = hActStart + SUM_W'(pixPerLine);
  assign hTotal    = hActEnd + SUM_W'(hFrontPorch);
  assign vActStart = SUM_W'(vSyncWidth) + SUM_W'(vBackPorch);
  assign vActEnd   = vActStart + SUM_W'(linesPerFrame);
  assign vTotal    = vActEnd + SUM_W'(vFrontPorch);

  assign startNow = !rst && enable && !running;
  assign tick     = !rst && enable && running && (divCnt == divLast);
  assign hLast    = (hCnt == hTotal - SUM_W'(1));
  assign vLast    = (vCnt == vTotal - SUM_W'(1));

  always_comb begin
    nextH = hCnt;
    nextV = vCnt;
    if (startNow) begin
      nextH = '0;
      nextV = '0;
    end else if (hLast) begin
      nextH = '0;
      nextV = vLast ? '0 : vCnt + SUM_W'(1);
    end else begin
      nextH = hCnt + SUM_W'(1);
    end
  end

  always_comb begin
    strobe.halt       = rst || !enable;
    strobe.load       = startNow || tick;
    strobe.frameWrap  = tick && hLast && vLast;
    strobe.nextActive = (nextH >= hActStart) && (nextH < hActEnd) &&
                        (nextV >= vActStart) && (nextV < vActEnd);
    strobe.nextHsync  = nextH < SUM_W'(hSyncWidth);
    strobe.nextVsync  = nextV < SUM_W'(vSyncWidth);
    strobe.pclkRise   = !rst && enable && running && !tick &&
                        (divCnt == divHalf - DIV_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      running <= 1'b0;
      divCnt  <= '0;
      hCnt    <= '0;
      vCnt    <= '0;
    end else begin
      running <= 1'b1;
      if (startNow || tick) begin
        divCnt <= '0;
        hCnt   <= nextH;
        vCnt   <= nextV;
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/lcdTimingPath.sv
module lcdTimingPath
  import lcdTimingPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AC_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  lcdStrobeT         strobe,
  input  logic              activeMode,
  input  logic [AC_W-1:0]   acPeriod,
  input  logic [DATA_W-1:0] pixData,
  input  logic              pixValid,
  input  logic              underflowClr,
  output logic              pixReady,
  output logic              underflow,
  output logic              lcdVsync,
  output logic              lcdHsync,
  output logic              lcdAc,
  output logic              lcdPclk,
  output logic [DATA_W-1:0] lcdData,
  output logic              slotActive
);
  logic            polarity;
  logic [AC_W-1:0] acCnt;

  assign pixReady = strobe.load && strobe.nextActive;
  assign lcdAc    = activeMode ? slotActive : polarity;

  always_ff @(posedge clk) begin
    if (strobe.halt) begin
      lcdHsync   <= 1'b0;
      lcdVsync   <= 1'b0;
      lcdPclk    <= 1'b0;
      lcdData    <= '0;
      slotActive <= 1'b0;
      polarity   <= 1'b0;
      acCnt      <= '0;
    end else if (strobe.load) begin
      lcdHsync   <= strobe.nextHsync;
      lcdVsync   <= strobe.nextVsync;
      lcdPclk    <= 1'b0;
      slotActive <= strobe.nextActive;
      lcdData    <= (strobe.nextActive && pixValid) ? pixData : '0;
      if (strobe.frameWrap) begin
        if (acCnt == acPeriod) begin
          polarity <= !polarity;
          acCnt    <= '0;
        end else begin
          acCnt <= acCnt + AC_W'(1);
        end
      end
    end else if (strobe.pclkRise && (activeMode || slotActive)) begin
      lcdPclk <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        underflow <= 1'b0;
    else if (pixReady && !pixValid) underflow <= 1'b1;
    else if (underflowClr)          underflow <= 1'b0;
  end
endmodule

// File: rtl/lcdTimingGen.sv
module lcdTimingGen
  import lcdTimingPkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int DIV_W  = 8,
  parameter int AC_W   = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              activeMode,
  input  logic [CNT_W-1:0]  pixPerLine,
  input  logic [CNT_W-1:0]  hSyncWidth,
  input  logic [CNT_W-1:0]  hBackPorch,
  input  logic [CNT_W-1:0]  hFrontPorch,
  input  logic [CNT_W-1:0]  linesPerFrame,
  input  logic [CNT_W-1:0]  vSyncWidth,
  input  logic [CNT_W-1:0]  vBackPorch,
  input  logic [CNT_W-1:0]  vFrontPorch,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [AC_W-1:0]   acPeriod,
  input  logic [DATA_W-1:0] pixData,
  input  logic              pixValid,
  output logic              pixReady,
  input  logic              underflowClr,
  output logic              underflow,
  output logic              lcdVsync,
  output logic              lcdHsync,
  output logic              lcdAc,
  output logic              lcdPclk,
  output logic [DATA_W-1:0] lcdData
);
  lcdStrobeT strobe;
  logic      slotActive;

  lcdTimingCtrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rst(rst), .enable(enable),
    .pixPerLine(pixPerLine), .hSyncWidth(hSyncWidth),
    .hBackPorch(hBackPorch), .hFrontPorch(hFrontPorch),
    .linesPerFrame(linesPerFrame), .vSyncWidth(vSyncWidth),
    .vBackPorch(vBackPorch), .vFrontPorch(vFrontPorch),
    .clkDiv(clkDiv), .strobe(strobe)
  );

  lcdTimingPath #(.DATA_W(DATA_W), .AC_W(AC_W)) path_i (
    .clk(clk), .rst(rst), .strobe(strobe), .activeMode(activeMode),
    .acPeriod(acPeriod), .pixData(pixData), .pixValid(pixValid),
    .underflowClr(underflowClr), .pixReady(pixReady),
    .underflow(underflow), .lcdVsync(lcdVsync), .lcdHsync(lcdHsync),
    .lcdAc(lcdAc), .lcdPclk(lcdPclk), .lcdData(lcdData),
    .slotActive(slotActive)
  );
endmodule

// File: rtl/lcdTimingChk.sv
module lcdTimingChk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              activeMode,
  input logic [DATA_W-1:0] pixData,
  input logic              pixValid,
  input logic              pixReady,
  input logic              underflowClr,
  input logic              underflow,
  input logic              lcdHsync,
  input logic              lcdVsync,
  input logic              lcdAc,
  input logic              lcdPclk,
  input logic [DATA_W-1:0] lcdData,
  input logic              slotActive
);
  assert_blank_when_off_R1: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (lcdData == '0 && !lcdPclk && !lcdAc && !lcdHsync && !lcdVsync));

  assert_data_moves_on_low_clk_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(lcdData) |-> !lcdPclk);

  assert_passive_clk_gated_R6: assert property (@(posedge clk) disable iff (rst)
    (!activeMode && lcdPclk) |-> slotActive);

  assert_enable_covers_data_R7: assert property (@(posedge clk) disable iff (rst)
    (activeMode && !lcdAc) |-> lcdData == '0);

  assert_hsync_outside_pixels_R3: assert property (@(posedge clk) disable iff (rst)
    lcdHsync |-> !slotActive);

  assert_fetch_lands_on_bus_R9: assert property (@(posedge clk) disable iff (rst)
    (pixReady && pixValid) |=> lcdData == $past(pixData));

  assert_underflow_sets_R10: assert property (@(posedge clk) disable iff (rst)
    (pixReady && !pixValid) |=> (underflow && lcdData == '0));

  assert_underflow_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (underflow && !underflowClr) |=> underflow);
endmodule

bind lcdTimingGen lcdTimingChk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .enable(enable), .activeMode(activeMode),
  .pixData(pixData), .pixValid(pixValid), .pixReady(pixReady),
  .underflowClr(underflowClr), .underflow(underflow),
  .lcdHsync(lcdHsync), .lcdVsync(lcdVsync), .lcdAc(lcdAc),
  .lcdPclk(lcdPclk), .lcdData(lcdData), .slotActive(slotActive)
);

// File: tb/lcdTimingGen_tb_top.sv
module lcdTimingGen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, enable = 0, activeMode = 0;
  logic [9:0] pixPerLine, hSyncWidth, hBackPorch, hFrontPorch;
  logic [9:0] linesPerFrame, vSyncWidth, vBackPorch, vFrontPorch;
  logic [7:0] clkDiv;
  logic [5:0] acPeriod;
  logic [15:0] pixData = 0;
  logic pixValid = 0, underflowClr = 0;
  logic pixReady, underflow, lcdVsync, lcdHsync, lcdAc, lcdPclk;
  logic [15:0] lcdData;

  int checks = 0, failures = 0;
  bit done = 0;
  int hs, hb, pw, hf, vs, vb, lc, vf, dv, acp;
  bit md;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcdTimingGen dut_i (.*);

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int effDiv(); return (dv < 2) ? 2 : dv; endfunction
  function automatic int hTot(); return hs + hb + pw + hf; endfunction
  function automatic int frameLen(); return hTot() * (vs + vb + lc + vf); endfunction
  function automatic bit slotAct(int s);
    int r = s % frameLen();
    int h = r % hTot();
    int v = r / hTot();
    return (h >= hs + hb) && (h < hs + hb + pw) && (v >= vs + vb) && (v < vs + vb + lc);
  endfunction
  function automatic bit slotHs(int s); return ((s % frameLen()) % hTot()) < hs; endfunction
  function automatic bit slotVs(int s); return ((s % frameLen()) / hTot()) < vs; endfunction
  function automatic bit slotPol(int s); return ((s / frameLen()) / (acp + 1)) % 2; endfunction

  task automatic applyCfg();
    hSyncWidth = 10'(hs); hBackPorch = 10'(hb); pixPerLine = 10'(pw); hFrontPorch = 10'(hf);
    vSyncWidth = 10'(vs); vBackPorch = 10'(vb); linesPerFrame = 10'(lc); vFrontPorch = 10'(vf);
    clkDiv = 8'(dv); acPeriod = 6'(acp); activeMode = md;
  endtask

  task automatic checkQuiet(string req);
    check(lcdHsync == 0 && lcdVsync == 0 && lcdPclk == 0 && lcdAc == 0 && pixReady == 0,
          req, {lcdHsync, lcdVsync, lcdPclk, lcdAc, pixReady}, 0);
    check(lcdData == 0, req, lcdData, 0);
  endtask

  task automatic runCfg(int frames, int validPct, bit doClr);
    int d, total;
    bit expUnder;
    logic [15:0] expData;
    applyCfg();
    d = effDiv();
    total = frames * frameLen() * d;
    @(negedge clk); rst = 1; enable = 0; pixValid = 0; underflowClr = 0;
    @(negedge clk);
    checkQuiet("R1");
    check(underflow == 0, "R1", underflow, 0);
    rst = 0;
    @(negedge clk);
    checkQuiet("R1");
    enable = 1;
    expUnder = 0; expData = 0;
    for (int t = 0; t < total; t++) begin
      int s = t / d, p = t % d, nt = t + 1;
      bit act, nact, expClk;
      @(negedge clk);
      act = slotAct(s);
      expClk = (p >= d / 2) && (md || act);
      check(lcdHsync == slotHs(s), (t == 0) ? "R2" : "R3", lcdHsync, slotHs(s));
      check(lcdVsync == slotVs(s), "R4", lcdVsync, slotVs(s));
      check(lcdPclk == expClk, (dv < 2) ? "R11" : (!md && !act) ? "R6" : "R5", lcdPclk, expClk);
      if (md) check(lcdAc == act, "R7", lcdAc, act);
      else    check(lcdAc == slotPol(s), "R8", lcdAc, slotPol(s));
      check(lcdData == (act ? expData : 16'h0), "R9", lcdData, act ? expData : 0);
      check(underflow == expUnder, "R10", underflow, expUnder);
      nact = (nt % d == 0) && slotAct(nt / d);
      check(pixReady == nact, "R9", pixReady, nact);
      pixValid = ($urandom % 100) < validPct;
      pixData  = 16'($urandom);
      underflowClr = doClr && ($urandom % 8 == 0);
      if (nact) expData = pixValid ? pixData : 16'h0;
      if (nact && !pixValid) expUnder = 1;
      else if (underflowClr) expUnder = 0;
    end
    @(negedge clk);
    enable = 0; underflowClr = 0; pixValid = 0;
    @(negedge clk);
    checkQuiet("R1");
    check(underflow == expUnder, "R1", underflow, expUnder);
  endtask

  initial begin
    void'($urandom(32'd1234));
    clkDiv = 4; acPeriod = 0;
    pixPerLine = 4; hSyncWidth = 1; hBackPorch = 1; hFrontPorch = 1;
    linesPerFrame = 2; vSyncWidth = 1; vBackPorch = 1; vFrontPorch = 1;
    // Directed: active mode, even divisor, random data gaps and clears
    hs = 1; hb = 2; pw = 4; hf = 1; vs = 1; vb = 1; lc = 3; vf = 1; dv = 4; acp = 0; md = 1;
    runCfg(2, 80, 1);
    // Directed: passive mode, odd divisor, polarity every frame
    hs = 2; hb = 1; pw = 3; hf = 2; vs = 2; vb = 1; lc = 2; vf = 1; dv = 3; acp = 0; md = 0;
    runCfg(3, 70, 1);
    // Directed: divisor below minimum, polarity every second frame, no underflow
    hs = 1; hb = 1; pw = 5; hf = 1; vs = 1; vb = 0; lc = 2; vf = 1; dv = 1; acp = 1; md = 0;
    runCfg(5, 100, 0);
    // Directed: zero divisor in active mode, constant starvation
    hs = 1; hb = 0; pw = 2; hf = 0; vs = 1; vb = 0; lc = 1; vf = 0; dv = 0; acp = 2; md = 1;
    runCfg(2, 0, 0);
    // Random geometries
    for (int k = 0; k < 6; k++) begin
      hs = 1 + $urandom % 3; hb = $urandom % 3; pw = 1 + $urandom % 5; hf = $urandom % 3;
      vs = 1 + $urandom % 2; vb = $urandom % 2; lc = 1 + $urandom % 3; vf = $urandom % 2;
      dv = 2 + $urandom % 5; acp = $urandom % 3; md = $urandom % 2;
      runCfg(2 + acp * 2, 60 + $urandom % 40, 1);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R2 act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule